// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The default depth is 64 words, and the depth can be set to any power of two from 64 to 8192. Writes and reads run on separate clocks. The two clocks may be unrelated, or both may be driven by one clock. Each side accepts a transfer only when both of its enable inputs are high.

The block has four status flags:
- Empty and almost-empty are produced on the read clock.
- Full and almost-full are produced on the write clock.

Each almost-flag compares the fill level against an offset register. Both offset registers reset to 7. Software reloads them through the write data bus by pulsing a load pin, and a small sequencer decides which register each load cycle targets.

Flow control follows stream conventions:
- `full` is the inverse of write-ready. A producer must hold its word while `full` is high. A word offered while full is dropped and does not disturb the stored contents.
- `empty` is the inverse of read-valid. A read request while empty returns nothing and moves nothing.

Read data is registered. An output enable turns the read data bus to high impedance.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wclk` edge only when `wr_en1` and `wr_en2` are both high, `ld` is low and the buffer is not full. A single enable on its own stores nothing.
- R2: A read takes place on a rising `rclk` edge when `rd_en1` and `rd_en2` are both high and the buffer is not empty. After that edge, `rd_data` holds the oldest stored word, and words come out in write order. A single enable on its own reads nothing.
- R3: `empty` is high exactly when no words are stored. After a write, `empty` falls within three `rclk` edges.
- R4: `full` is high exactly when DEPTH words are stored. After a read, `full` falls within three `wclk` edges.
- R5: With offsets E and F, `almost_empty` is high when the fill level is at most E, and `almost_full` is high when the fill level is at least DEPTH−F. Both E and F are 7 after reset.
- R6: A `wclk` edge with `ld` and `wr_en1` high is a load cycle. For depths up to 512, each offset takes one load cycle: `wr_data[AW-1:0]` is taken, where AW = log2(DEPTH). For larger depths, each offset takes two load cycles, low slice first. Load cycles fill the empty offset first and then the full offset, after which the sequence wraps back to the empty offset. A load cycle never stores data, even when `wr_en2` is also high.
- R7: A write attempted while full and a read attempted while empty leave both pointers unchanged. The stored contents and their order are unaffected.
- R8: While `oe` is low, every bit of `rd_data` is high impedance.
- R9: While `rst_n` is low, both pointers are cleared, both offsets return to 7 and the load sequencer returns to the empty offset. After reset, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and `rd_data` is 0 when `oe` is high.
- R10: The Gray-coded pointers that cross between clock domains change by at most one bit per edge of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en1 | input | 1 | Write enable, first qualifier; also starts a load cycle with `ld` |
| wr_en2 | input | 1 | Write enable, second qualifier |
| ld | input | 1 | Offset load select |
| wr_data | input | 9 | Write data, also the offset load bus |
| rd_en1 | input | 1 | Read enable, first qualifier |
| rd_en2 | input | 1 | Read enable, second qualifier |
| oe | input | 1 | Output enable for `rd_data` |
| rd_data | output | 9 | Registered read data, high impedance while `oe` is low |
| empty | output | 1 | No words stored (read clock) |
| full | output | 1 | DEPTH words stored (write clock) |
| almost_empty | output | 1 | Fill level at or below the empty offset (read clock) |
| almost_full | output | 1 | Fill level at or above DEPTH minus the full offset (write clock) |

## Verification
A corrupted pointer shows up as a wrong flag at a particular fill level. A corrupted RAM index shows up as a wrong word on the first read that touches it. The bench therefore steps the fill level through every value from 0 to DEPTH and checks all four flags at each level, settling three edges after every move. A wrong offset register, or a load sequencer on the wrong step, shows up as an almost-flag threshold off by at least one level during the sweep that follows the load. A pointer that moves on an ignored request shows up as a data sequence that is shifted or out of order when the buffer is drained.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int DATA_W     = 9;
  localparam int DEF_OFFSET = 7;
endpackage

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/1ps
module dcf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(stage2 >> i);
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
  parameter int DW    = 9,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int LW   = (AW + DW - 1) / DW,
  localparam int NS   = 2 * LW,
  localparam int SW   = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en1,
  input  logic          wr_en2,
  input  logic          ld,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] rptr_sync,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic          push,
  output logic          full,
  output logic          almost_full,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  logic [PW-1:0] level, wnext;
  logic [SW-1:0] step;
  logic          ld_go, to_full;
  int unsigned   slice;

  assign level       = wptr - rptr_sync;
  assign full        = (level == PW'(DEPTH));
  assign almost_full = (level >= (PW'(DEPTH) - PW'(af_off)));
  assign ld_go       = ld & wr_en1;
  assign push        = wr_en1 & wr_en2 & ~ld & ~full;
  assign wnext       = wptr + PW'(1);
  assign slice       = int'(step) % LW;
  assign to_full     = (int'(step) / LW) == 1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (push) begin
      wptr  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      ae_off <= AW'(dcf_pkg::DEF_OFFSET);
      af_off <= AW'(dcf_pkg::DEF_OFFSET);
    end else if (ld_go) begin
      for (int b = 0; b < AW; b++) begin
        if ((b / DW) == int'(slice)) begin
          if (to_full) af_off[b] <= din[b % DW];
          else         ae_off[b] <= din[b % DW];
        end
      end
      step <= (step == SW'(NS - 1)) ? '0 : step + SW'(1);
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en1,
  input  logic          rd_en2,
  input  logic [PW-1:0] wptr_sync,
  input  logic [AW-1:0] ae_off,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic          pop,
  output logic          empty,
  output logic          almost_empty
);
  logic [PW-1:0] level, rnext;

  assign level        = wptr_sync - rptr;
  assign empty        = (level == '0);
  assign almost_empty = (level <= PW'(ae_off));
  assign pop          = rd_en1 & rd_en2 & ~empty;
  assign rnext        = rptr + PW'(1);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rptr  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DW    = dcf_pkg::DATA_W,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en1,
  input  logic          wr_en2,
  input  logic          ld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en1,
  input  logic          rd_en2,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  logic [PW-1:0] wptr_bin, wgray, rptr_bin, rgray, wptr_sync, rptr_sync;
  logic [AW-1:0] ae_off, af_off;
  logic          push, pop;
  logic [DW-1:0] q;

  dcf_wr_side #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en1(wr_en1), .wr_en2(wr_en2), .ld(ld),
    .din(wr_data), .rptr_sync(rptr_sync), .wptr(wptr_bin), .wgray(wgray),
    .push(push), .full(full), .almost_full(almost_full),
    .ae_off(ae_off), .af_off(af_off)
  );

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_en1(rd_en1), .rd_en2(rd_en2),
    .wptr_sync(wptr_sync), .ae_off(ae_off), .rptr(rptr_bin), .rgray(rgray),
    .pop(pop), .empty(empty), .almost_empty(almost_empty)
  );

  dcf_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_sync)
  );

  dcf_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_sync)
  );

  dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .we(push), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
    .re(pop), .raddr(rptr_bin[AW-1:0]), .rdata(q)
  );

  assign rd_data = oe ? q : {DW{1'bz}};
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
module dcfifo_pflag_chk #(
  parameter int PW = 7
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en1,
  input logic          wr_en2,
  input logic          ld,
  input logic          rd_en1,
  input logic          rd_en2,
  input logic          empty,
  input logic          full,
  input logic          almost_empty,
  input logic          almost_full,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  // R7
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en1 && wr_en2 && full) |=> $stable(wptr));

  // R7
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en1 && rd_en2 && empty) |=> $stable(rptr));

  // R6
  load_no_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld && wr_en1) |=> $stable(wptr));

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));

  // R5
  full_implies_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);

  // R5
  empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
  .wr_en1(wr_en1), .wr_en2(wr_en2), .ld(ld),
  .rd_en1(rd_en1), .rd_en2(rd_en2),
  .empty(empty), .full(full),
  .almost_empty(almost_empty), .almost_full(almost_full),
  .wptr(wptr_bin), .rptr(rptr_bin), .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_pflag_bench.sv
`timescale 1ns/1ps
module dcfifo_pflag_bench;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic clk = 1'b0;
  logic rst_n, wr_en1, wr_en2, ld, rd_en1, rd_en2, oe;
  logic [DW-1:0] wr_data;
  wire  [DW-1:0] rd_data;
  logic empty, full, almost_empty, almost_full;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH)) u_dcfifo_pflag (
    .wclk(clk), .rclk(clk), .rst_n(rst_n),
    .wr_en1(wr_en1), .wr_en2(wr_en2), .ld(ld), .wr_data(wr_data),
    .rd_en1(rd_en1), .rd_en2(rd_en2), .oe(oe), .rd_data(rd_data),
    .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic logic [DW-1:0] pat(int i, int seed);
    return DW'((i * 37 + seed) & 9'h1ff);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic push(logic [DW-1:0] d);
    wr_data = d; wr_en1 = 1'b1; wr_en2 = 1'b1;
    @(negedge clk);
    wr_en1 = 1'b0; wr_en2 = 1'b0;
  endtask

  task automatic pop();
    rd_en1 = 1'b1; rd_en2 = 1'b1;
    @(negedge clk);
    rd_en1 = 1'b0; rd_en2 = 1'b0;
  endtask

  task automatic load(logic [DW-1:0] v);
    ld = 1'b1; wr_en1 = 1'b1; wr_en2 = 1'b1; wr_data = v;
    @(negedge clk);
    ld = 1'b0; wr_en1 = 1'b0; wr_en2 = 1'b0;
  endtask

  task automatic flags(int lvl, int eo, int fo);
    chk("R3 empty", DW'(empty), DW'(lvl == 0));
    chk("R4 full", DW'(full), DW'(lvl == DEPTH));
    chk("R5 almost_empty", DW'(almost_empty), DW'(lvl <= eo));
    chk("R5 almost_full", DW'(almost_full), DW'(lvl >= DEPTH - fo));
  endtask

  task automatic fill_sweep(int eo, int fo, int seed);
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      settle();
      flags(lvl, eo, fo);
      if (lvl < DEPTH) push(pat(lvl, seed));
    end
  endtask

  task automatic drain_sweep(int eo, int fo, int seed);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      chk("R2 order", rd_data, pat(i, seed));
      settle();
      flags(DEPTH - 1 - i, eo, fo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en1 = 0; wr_en2 = 0; ld = 0; rd_en1 = 0; rd_en2 = 0;
    oe = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    flags(0, 7, 7);
    chk("R9 rd_data", rd_data, '0);

    // R8 tri-state
    oe = 1'b0; #0.5;
    checks++;
    if (rd_data !== {DW{1'bz}}) begin
      fails++; $display("FAIL R8: actual %b expected all z", rd_data);
    end
    oe = 1'b1;

    // R1 single enables do not store
    wr_data = 9'h055; wr_en1 = 1'b1; @(negedge clk); wr_en1 = 1'b0;
    wr_en2 = 1'b1; @(negedge clk); wr_en2 = 1'b0;
    settle();
    chk("R1 single enable", DW'(empty), 9'd1);

    // R7 read while empty, then one word round trip
    pop(); settle();
    push(9'h123); settle();
    chk("R3 empty after write", DW'(empty), 9'd0);
    pop();
    chk("R7 data after empty read", rd_data, 9'h123);
    settle();
    chk("R3 empty after drain", DW'(empty), 9'd1);

    // R3 R4 R5 full sweep with default offsets
    fill_sweep(7, 7, 5);
    // R7 write while full is dropped
    push(9'h1aa); settle();
    flags(DEPTH, 7, 7);
    // R2 single read enables read nothing
    rd_en1 = 1'b1; @(negedge clk); rd_en1 = 1'b0;
    rd_en2 = 1'b1; @(negedge clk); rd_en2 = 1'b0;
    settle();
    chk("R2 single enable", DW'(full), 9'd1);
    drain_sweep(7, 7, 5);

    // R6 load sequence: empty offset, full offset, wrap to empty offset
    load(9'd20); load(9'd10); load(9'd30);
    settle();
    chk("R6 load stores no data", DW'(empty), 9'd1);
    fill_sweep(30, 10, 11);

    // R9 reset while full restores defaults
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R9 empty after reset", DW'(empty), 9'd1);
    fill_sweep(7, 7, 3);
    drain_sweep(7, 7, 3);

    // R6 sequencer restarts at empty offset after reset
    load(9'd2);
    fill_sweep(2, 7, 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule